// File: doc/BRIEF.md
# Uncached Load Forwarding Path

This block answers a load that targets uncached space with the bytes it can take from stores still held in the uncached request buffer. The load presents a full address and a byte-enable mask; the block compares them with every buffer entry, then merges the data of the matching store entries into a forwarded word. It also returns a per-byte valid mask, so the load unit knows which lanes came from the buffer and which it must still fetch from the bus.

The lookup takes two clock cycles. In the first, the block compares the block-aligned addresses and checks the masks for overlap, and registers a match vector. In the second, it merges the bytes and registers the result. Entry state arrives as flat input vectors that the surrounding buffer drives. Each entry carries a valid bit, a store bit, an age flag, an address, a byte mask and data.

One address can be held by at most two entries at once. One of them is already on the bus, and the other is a younger store parked behind it. The forwarded bytes then follow age order: a lane written by the younger entry takes its byte, and a lane that only the older entry wrote takes the older byte.

Top module: `ulf_forward`

## Requirements
- R1: While `rstN` is low, and on the first edge after it goes low, `fwdValid` is 0 and `fwdMask` and `fwdData` are all zero.
- R2: A request sampled with `ldValid` high at clock edge k shows its result on the outputs after edge k+1 and holds it until edge k+2. After an edge that saw no request one cycle earlier, `fwdValid` is 0.
- R3: An entry takes part only when its `entryValid` bit is 1 and its `entryStore` bit is 1 (1 = store, 0 = load). Load entries and invalid entries never contribute.
- R4: The address compare ignores the low log2(BYTES) offset bits. All bits above them must be equal.
- R5: An entry matches only if its byte mask overlaps the load mask in at least one lane.
- R6: `fwdMask` equals the load mask ANDed with the OR of the byte masks of all matching entries, and `fwdValid` is 1 exactly when `fwdMask` is non-zero.
- R7: With one matching entry, each lane set in `fwdMask` carries that entry's byte. Byte i is bits [8i+7:8i] of the word, and entry e occupies bits [e*8*BYTES +: 8*BYTES] of `entryData`.
- R8: With two matching entries, a lane that the entry with `entryYoung` = 1 writes takes that entry's byte. A lane that only the entry with `entryYoung` = 0 writes takes the older byte.
- R9: If no entry matches, `fwdValid` is 0 and `fwdMask` and `fwdData` are zero. In every case a lane clear in `fwdMask` reads as zero in `fwdData`.
- R10: Requests on back-to-back cycles are answered in order, one per cycle, each on its own two-cycle schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ldValid | input | 1 | Lookup request strobe |
| ldAddr | input | ADDR_W | Load address |
| ldMask | input | BYTES | Load byte enables |
| entryValid | input | NUM_ENTRIES | Entry holds a request |
| entryStore | input | NUM_ENTRIES | Entry is a store (1) or a load (0) |
| entryYoung | input | NUM_ENTRIES | Entry waits behind an older same-address entry |
| entryAddr | input | NUM_ENTRIES*ADDR_W | Entry addresses, entry e at [e*ADDR_W +: ADDR_W] |
| entryMask | input | NUM_ENTRIES*BYTES | Entry byte masks, entry e at [e*BYTES +: BYTES] |
| entryData | input | NUM_ENTRIES*BYTES*8 | Entry data, entry e at [e*8*BYTES +: 8*BYTES] |
| fwdValid | output | 1 | Some lane was forwarded |
| fwdMask | output | BYTES | Forwarded lane mask |
| fwdData | output | BYTES*8 | Forwarded bytes |

## Verification
The assertions check on every cycle the properties that hold for any entry contents. They check the reset clearing, the two-cycle link between a request and a valid result, that the forwarded mask stays inside the mask the load asked with, and that lanes not forwarded read zero. Only the bench scenarios can show the values themselves. These are which entry wins a contended lane, that offset bits are ignored while block bits are compared, that load and invalid entries drop out, and that back-to-back requests keep their own results.

// File: rtl/ulf_pkg.sv
package ulf_pkg;

  typedef struct packed {
    logic captureReq;
    logic captureOut;
  } fwdStrobe_t;

endpackage

// File: rtl/ulf_ctrl.sv
module ulf_ctrl
  import ulf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ldValid,
  output fwdStrobe_t strobe
);

  logic s1Valid;

  always_ff @(posedge clk) begin
    if (!rstN) s1Valid <= 1'b0;
    else       s1Valid <= ldValid;
  end

  always_comb begin
    strobe.captureReq = ldValid & rstN;
    strobe.captureOut = s1Valid;
  end

endmodule

// File: rtl/ulf_match.sv
module ulf_match #(
  parameter int ADDR_W = 16,
  parameter int BYTES  = 8
) (
  input  logic              entryValid,
  input  logic              entryStore,
  input  logic [ADDR_W-1:0] entryAddr,
  input  logic [BYTES-1:0]  entryMask,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [BYTES-1:0]  ldMask,
  output logic              hit
);

  localparam int OFF_W = $clog2(BYTES);

  logic blockEq;
  logic laneOverlap;

  always_comb begin
    blockEq     = (entryAddr[ADDR_W-1:OFF_W] == ldAddr[ADDR_W-1:OFF_W]);
    laneOverlap = |(entryMask & ldMask);
    hit         = entryValid & entryStore & blockEq & laneOverlap;
  end

endmodule

// File: rtl/ulf_dpath.sv
module ulf_dpath
  import ulf_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int ADDR_W      = 16,
  parameter int BYTES       = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  fwdStrobe_t                     strobe,
  input  logic [ADDR_W-1:0]              ldAddr,
  input  logic [BYTES-1:0]               ldMask,
  input  logic [NUM_ENTRIES-1:0]         entryValid,
  input  logic [NUM_ENTRIES-1:0]         entryStore,
  input  logic [NUM_ENTRIES-1:0]         entryYoung,
  input  logic [NUM_ENTRIES*ADDR_W-1:0]  entryAddr,
  input  logic [NUM_ENTRIES*BYTES-1:0]   entryMask,
  input  logic [NUM_ENTRIES*BYTES*8-1:0] entryData,
  output logic                           fwdValid,
  output logic [BYTES-1:0]               fwdMask,
  output logic [BYTES*8-1:0]             fwdData
);

  localparam int WORD_W = BYTES * 8;

  logic [NUM_ENTRIES-1:0] hitNow;
  logic [NUM_ENTRIES-1:0] matchS1;
  logic [BYTES-1:0]       maskS1;
  logic [BYTES-1:0]       mergedMask;
  logic [WORD_W-1:0]      mergedData;

  // Stage 1: one comparator per entry
  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_cmp
    ulf_match #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_match (
      .entryValid (entryValid[e]),
      .entryStore (entryStore[e]),
      .entryAddr  (entryAddr[e*ADDR_W +: ADDR_W]),
      .entryMask  (entryMask[e*BYTES +: BYTES]),
      .ldAddr     (ldAddr),
      .ldMask     (ldMask),
      .hit        (hitNow[e])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchS1 <= '0;
      maskS1  <= '0;
    end else if (strobe.captureReq) begin
      matchS1 <= hitNow;
      maskS1  <= ldMask;
    end else begin
      matchS1 <= '0;
      maskS1  <= '0;
    end
  end

  // Stage 2: lane merge, younger entry overlays older
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    logic       youngHit;
    logic       oldHit;
    logic [7:0] youngByte;
    logic [7:0] oldByte;

    always_comb begin
      youngHit  = 1'b0;
      oldHit    = 1'b0;
      youngByte = '0;
      oldByte   = '0;
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        if (matchS1[e] && entryMask[e*BYTES + b]) begin
          if (entryYoung[e]) begin
            youngHit  = 1'b1;
            youngByte = youngByte | entryData[e*WORD_W + b*8 +: 8];
          end else begin
            oldHit  = 1'b1;
            oldByte = oldByte | entryData[e*WORD_W + b*8 +: 8];
          end
        end
      end
      mergedMask[b] = maskS1[b] & (youngHit | oldHit);
      if (!mergedMask[b])  mergedData[b*8 +: 8] = 8'h00;
      else if (youngHit)   mergedData[b*8 +: 8] = youngByte;
      else                 mergedData[b*8 +: 8] = oldByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !strobe.captureOut) begin
      fwdValid <= 1'b0;
      fwdMask  <= '0;
      fwdData  <= '0;
    end else begin
      fwdValid <= |mergedMask;
      fwdMask  <= mergedMask;
      fwdData  <= mergedData;
    end
  end

endmodule

// File: rtl/ulf_forward.sv
module ulf_forward
  import ulf_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int ADDR_W      = 16,
  parameter int BYTES       = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           ldValid,
  input  logic [ADDR_W-1:0]              ldAddr,
  input  logic [BYTES-1:0]               ldMask,
  input  logic [NUM_ENTRIES-1:0]         entryValid,
  input  logic [NUM_ENTRIES-1:0]         entryStore,
  input  logic [NUM_ENTRIES-1:0]         entryYoung,
  input  logic [NUM_ENTRIES*ADDR_W-1:0]  entryAddr,
  input  logic [NUM_ENTRIES*BYTES-1:0]   entryMask,
  input  logic [NUM_ENTRIES*BYTES*8-1:0] entryData,
  output logic                           fwdValid,
  output logic [BYTES-1:0]               fwdMask,
  output logic [BYTES*8-1:0]             fwdData
);

  fwdStrobe_t strobe;

  ulf_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .ldValid (ldValid),
    .strobe  (strobe)
  );

  ulf_dpath #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .ADDR_W      (ADDR_W),
    .BYTES       (BYTES)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .ldAddr     (ldAddr),
    .ldMask     (ldMask),
    .entryValid (entryValid),
    .entryStore (entryStore),
    .entryYoung (entryYoung),
    .entryAddr  (entryAddr),
    .entryMask  (entryMask),
    .entryData  (entryData),
    .fwdValid   (fwdValid),
    .fwdMask    (fwdMask),
    .fwdData    (fwdData)
  );

endmodule

// File: rtl/ulf_checker.sv
module ulf_checker #(
  parameter int NUM_ENTRIES = 4,
  parameter int ADDR_W      = 16,
  parameter int BYTES       = 8
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           ldValid,
  input logic [ADDR_W-1:0]              ldAddr,
  input logic [BYTES-1:0]               ldMask,
  input logic [NUM_ENTRIES-1:0]         entryValid,
  input logic [NUM_ENTRIES-1:0]         entryStore,
  input logic [NUM_ENTRIES-1:0]         entryYoung,
  input logic [NUM_ENTRIES*ADDR_W-1:0]  entryAddr,
  input logic [NUM_ENTRIES*BYTES-1:0]   entryMask,
  input logic [NUM_ENTRIES*BYTES*8-1:0] entryData,
  input logic                           fwdValid,
  input logic [BYTES-1:0]               fwdMask,
  input logic [BYTES*8-1:0]             fwdData
);

  logic [1:0] sinceReset;

  always_ff @(posedge clk) begin
    if (!rstN)                 sinceReset <= 2'd0;
    else if (sinceReset != 2'd2) sinceReset <= sinceReset + 2'd1;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> (!fwdValid && fwdMask == '0 && fwdData == '0));

  p_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    (fwdValid && sinceReset == 2'd2) |-> $past(ldValid, 2));

  p_mask_subset_r6: assert property (@(posedge clk) disable iff (!rstN)
    (sinceReset == 2'd2) |-> ((fwdMask & ~$past(ldMask, 2)) == '0));

  p_empty_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    !fwdValid |-> (fwdMask == '0 && fwdData == '0));

  for (genvar b = 0; b < BYTES; b++) begin : g_lane_chk
    p_lane_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
      !fwdMask[b] |-> (fwdData[b*8 +: 8] == 8'h00));
  end

endmodule

bind ulf_forward ulf_checker #(
  .NUM_ENTRIES (NUM_ENTRIES),
  .ADDR_W      (ADDR_W),
  .BYTES       (BYTES)
) u_chk (.*);

// File: tb/tb_ulf_forward.sv
module tb_ulf_forward;

  localparam int CLK_PERIOD = 10;
  localparam int N   = 4;
  localparam int AW  = 16;
  localparam int NB  = 8;
  localparam int WW  = NB * 8;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [NB-1:0] mask;
    logic          expV;
    logic [NB-1:0] expM;
    logic [WW-1:0] expD;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{16'h1000, 8'hFF, 1'b1, 8'h3F, 64'h0000_2524_2322_1110}, // R8 R6 two entries
    '{16'h1006, 8'h03, 1'b1, 8'h03, 64'h0000_0000_0000_1110}, // R4 R7 offset ignored
    '{16'h1000, 8'hC0, 1'b0, 8'h00, 64'h0},                   // R5 no lane overlap
    '{16'h2000, 8'hFF, 1'b0, 8'h00, 64'h0},                   // R3 load entry
    '{16'h3001, 8'hFF, 1'b1, 8'hF0, 64'h4746_4544_0000_0000}, // R7 R6 single
    '{16'h1008, 8'hFF, 1'b0, 8'h00, 64'h0},                   // R4 R9 other block
    '{16'h1000, 8'h0C, 1'b1, 8'h0C, 64'h0000_0000_2322_0000}, // R8 younger wins
    '{16'h1000, 8'h30, 1'b1, 8'h30, 64'h0000_2524_0000_0000}  // R7 younger only
  };

  logic            clk = 1'b0;
  logic            rstN;
  logic            ldValid;
  logic [AW-1:0]   ldAddr;
  logic [NB-1:0]   ldMask;
  logic [N-1:0]    entryValid;
  logic [N-1:0]    entryStore;
  logic [N-1:0]    entryYoung;
  logic [N*AW-1:0] entryAddr;
  logic [N*NB-1:0] entryMask;
  logic [N*WW-1:0] entryData;
  logic            fwdValid;
  logic [NB-1:0]   fwdMask;
  logic [WW-1:0]   fwdData;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ulf_forward #(.NUM_ENTRIES(N), .ADDR_W(AW), .BYTES(NB)) dut (
    .clk, .rstN, .ldValid, .ldAddr, .ldMask,
    .entryValid, .entryStore, .entryYoung, .entryAddr, .entryMask, .entryData,
    .fwdValid, .fwdMask, .fwdData
  );

  task automatic checkOut(input string tag, input logic ev,
                          input logic [NB-1:0] em, input logic [WW-1:0] ed);
    checks++;
    if (fwdValid !== ev || fwdMask !== em || fwdData !== ed) begin
      failures++;
      $display("FAIL %s: actual v=%0b m=%h d=%h expected v=%0b m=%h d=%h",
               tag, fwdValid, fwdMask, fwdData, ev, em, ed);
    end
  endtask

  // Called at a falling edge; returns at the falling edge where the result is visible.
  task automatic lookup(input logic [AW-1:0] a, input logic [NB-1:0] m);
    ldValid = 1'b1; ldAddr = a; ldMask = m;
    @(negedge clk);
    ldValid = 1'b0; ldAddr = '0; ldMask = '0;
    @(negedge clk);
  endtask

  initial begin
    rstN = 1'b0; ldValid = 1'b0; ldAddr = '0; ldMask = '0;
    entryValid = 4'b1111;
    entryStore = 4'b1011;
    entryYoung = 4'b0010;
    entryAddr  = {16'h3000, 16'h2000, 16'h1004, 16'h1000};
    entryMask  = {8'hF0, 8'hFF, 8'h3C, 8'h0F};
    for (int e = 0; e < N; e++)
      for (int b = 0; b < NB; b++)
        entryData[e*WW + b*8 +: 8] = 8'(8'h10 * (e + 1) + b);

    repeat (3) @(negedge clk);
    checkOut("R1 reset state", 1'b0, '0, '0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      lookup(VECS[i].addr, VECS[i].mask);
      checkOut($sformatf("vector %0d", i), VECS[i].expV, VECS[i].expM, VECS[i].expD);
    end

    // R2: nothing one cycle after the request, result the cycle after
    ldValid = 1'b1; ldAddr = 16'h1000; ldMask = 8'hFF;
    @(negedge clk);
    ldValid = 1'b0;
    checkOut("R2 not yet visible", 1'b0, '0, '0);
    @(negedge clk);
    checkOut("R2 visible", 1'b1, 8'h3F, 64'h0000_2524_2322_1110);
    @(negedge clk);
    checkOut("R2 idle clears", 1'b0, '0, '0);

    // R10: back-to-back requests
    ldValid = 1'b1; ldAddr = 16'h1000; ldMask = 8'h0C;
    @(negedge clk);
    ldAddr = 16'h3000; ldMask = 8'h30;
    @(negedge clk);
    ldValid = 1'b0; ldMask = '0;
    checkOut("R10 first", 1'b1, 8'h0C, 64'h0000_0000_2322_0000);
    @(negedge clk);
    checkOut("R10 second", 1'b1, 8'h30, 64'h0000_4544_0000_0000);

    // R3: invalid store entry drops out
    entryValid = 4'b0111;
    lookup(16'h3000, 8'hFF);
    checkOut("R3 invalid entry", 1'b0, '0, '0);
    entryValid = 4'b1111;

    // R8: age flag swapped, entry 0 now younger
    entryYoung = 4'b0001;
    lookup(16'h1000, 8'h0C);
    checkOut("R8 swapped age", 1'b1, 8'h0C, 64'h0000_0000_1312_0000);
    lookup(16'h1000, 8'h3F);
    checkOut("R8 swapped age mixed", 1'b1, 8'h3F, 64'h0000_2524_1312_1110);

    // R1: reset mid-flight discards the pending lookup
    ldValid = 1'b1; ldAddr = 16'h1000; ldMask = 8'hFF;
    @(negedge clk);
    ldValid = 1'b0; rstN = 1'b0;
    @(negedge clk);
    checkOut("R1 reset in flight", 1'b0, '0, '0);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1 after reset", 1'b0, '0, '0);

    done = 1'b1;
  end

  initial begin : watchdog
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule